// File: doc/BRIEF.md
# Coherent Store Buffer with Strict/Relaxed Load Forwarding

This block sits between a processor's memory port and a write-back cache that uses an invalidation protocol. Every store from the processor is treated as a miss on a clean one-word line. The block holds the store in a small in-order buffer and issues an exclusive-ownership request for its address. The store stays in the buffer until the matching exclusive reply comes back. That reply marks the point where the store is ordered against other stores to the same word. On the reply, the block writes the store into the cache and drops it from the buffer.

Loads look up the buffer before the cache. A mode bit chooses between two behaviours for a load that hits a buffered store:
- In relaxed mode, the youngest matching store's data is returned at once.
- In strict mode, the load is held off until no buffered store to that address remains. It then reads the cache, which by that point holds the serialized value.

A load that matches nothing reads the cache directly and suffers no added delay. The mode is latched only while the buffer is empty, so the rule in force never changes under a pending store.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the buffer is empty, `st_ready` is 1, `req_valid` is 0, `cw_valid` is 0, `sb_err` is 0, and the latched mode is relaxed.
- R2: A store is taken when `st_valid` and `st_ready` are both 1. `st_ready` is 0 exactly when 4 stores are held.
- R3: One exclusive request is issued for each held store, oldest unrequested first. Its `req_addr` is that store's address. `req_valid` and `req_addr` stay unchanged until `req_ready` is seen.
- R4: A reply (`rsp_valid`) whose `rsp_addr` equals the address of the oldest held store, when that store's request has already been accepted, retires the store. In that same cycle `cw_valid` is 1 and `cw_addr`/`cw_data` carry the store's address and data. The store leaves the buffer at the next edge.
- R5: A reply that does not meet the condition of R4 writes nothing to the cache and removes nothing from the buffer. It sets `sb_err`, which then stays 1 until reset.
- R6: In relaxed mode, a load whose address equals the address of one or more held stores has `ld_ready` 1 in the same cycle. Its `ld_data` is the data of the youngest such store.
- R7: In strict mode, a load whose address equals that of any held store has `ld_ready` 0. Once no matching store remains, `ld_ready` is 1 and `ld_data` is the cache data.
- R8: A load matching no held store has `ld_ready` 1 in the same cycle. `cache_rd_addr` equals `ld_addr` at all times, and `ld_data` equals `cache_rd_data`.
- R9: At each clock edge where the buffer is empty before the edge, `strict_mode` (1 = strict) is latched. Changes to `strict_mode` while stores are held have no effect.
- R10: Address matching compares all `AW` address bits. Addresses that differ only in high bits never forward to each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_mode | input | 1 | Forwarding rule request, 1 = strict |
| st_valid | input | 1 | Processor store valid |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Processor load valid |
| ld_ready | output | 1 | Load completes this cycle |
| ld_addr | input | AW | Load word address |
| ld_data | output | DW | Load result, valid with ld_valid and ld_ready |
| cache_rd_addr | output | AW | Cache read address |
| cache_rd_data | input | DW | Cache read data, same cycle |
| req_valid | output | 1 | Exclusive request valid |
| req_ready | input | 1 | Interconnect accepts the request |
| req_addr | output | AW | Exclusive request address |
| rsp_valid | input | 1 | Exclusive reply arriving |
| rsp_addr | input | AW | Address tag of the reply |
| cw_valid | output | 1 | Cache write strobe for a retiring store |
| cw_addr | output | AW | Cache write address |
| cw_data | output | DW | Cache write data |
| sb_err | output | 1 | Sticky out-of-order reply flag |

## Verification
Retirement of the oldest store and arrival of a new store often fall in the same cycle. A load to an address whose store is retiring in that very cycle is another such coincidence. Both are provoked by random stimulus over a small address set with many collisions: reply arrival is randomized, and a stretch with `req_ready` held low first fills the buffer. A queue-based model in the bench predicts the outputs for each cycle. In each coincident cycle it checks four things:
- the occupancy after the edge;
- the cache-write contents;
- the forwarded value, or the stall in strict mode;
- the cache value returned once the stall lifts.

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strict_mode,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  output logic [DW-1:0] ld_data,
  output logic [AW-1:0] cache_rd_addr,
  input  logic [DW-1:0] cache_rd_data,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_addr,
  output logic          cw_valid,
  output logic [AW-1:0] cw_addr,
  output logic [DW-1:0] cw_data,
  output logic          sb_err
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

  logic [AW-1:0] e_addr [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [PW-1:0] head, tail;
  logic [PW:0]   count, nsent;
  logic          mode_q, err_q;

  logic push, req_fire, rsp_ok, hit;
  logic [DW-1:0] fwd_data;
  logic [PW-1:0] iss;

  assign st_ready  = count != FULL;
  assign push      = st_valid && st_ready;
  assign iss       = head + nsent[PW-1:0];
  assign req_valid = nsent != count;
  assign req_addr  = e_addr[iss];
  assign req_fire  = req_valid && req_ready;
  assign rsp_ok    = rsp_valid && (nsent != '0) && (rsp_addr == e_addr[head]);
  assign cw_valid  = rsp_ok;
  assign cw_addr   = e_addr[head];
  assign cw_data   = e_data[head];
  assign sb_err    = err_q;

  always_comb begin
    logic [PW-1:0] idx;
    hit      = 1'b0;
    fwd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head + PW'(i);
      if ((PW+1)'(i) < count && e_addr[idx] == ld_addr) begin
        hit      = 1'b1;
        fwd_data = e_data[idx];
      end
    end
  end

  assign cache_rd_addr = ld_addr;
  assign ld_ready      = !(mode_q && hit);
  assign ld_data       = hit ? fwd_data : cache_rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      tail   <= '0;
      count  <= '0;
      nsent  <= '0;
      mode_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (count == '0) mode_q <= strict_mode;
      if (rsp_valid && !rsp_ok) err_q <= 1'b1;
      if (push) tail <= tail + 1'b1;
      if (rsp_ok) head <= head + 1'b1;
      count <= count + (PW+1)'(push) - (PW+1)'(rsp_ok);
      nsent <= nsent + (PW+1)'(req_fire) - (PW+1)'(rsp_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      e_addr[tail] <= st_addr;
      e_data[tail] <= st_data;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL && nsent <= count);

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  assert_retire_pops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !push |=> count == $past(count) - 1'b1);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sb_err |=> sb_err);

  assert_bad_rsp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_addr != e_addr[head] |-> !cw_valid);

  assert_relaxed_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q && ld_valid && hit |-> ld_ready && ld_data == fwd_data);

  assert_strict_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_ready |-> mode_q && count != '0);

  assert_miss_cache_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !hit |-> ld_ready && ld_data == cache_rd_data);

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count != '0 |=> mode_q == $past(mode_q));
endmodule

// File: tb/test_store_fwd_buffer.sv
`timescale 1ns/1ps
module test_store_fwd_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strict_mode = 1'b0;
  logic        st_valid = 1'b0, st_ready;
  logic [15:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic        ld_valid = 1'b0, ld_ready;
  logic [15:0] ld_addr = '0;
  logic [31:0] ld_data;
  logic [15:0] cache_rd_addr;
  logic [31:0] cache_rd_data = '0;
  logic        req_valid, req_ready = 1'b0;
  logic [15:0] req_addr;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_addr = '0;
  logic        cw_valid;
  logic [15:0] cw_addr;
  logic [31:0] cw_data;
  logic        sb_err;

  always #4 clk = ~clk;

  store_fwd_buffer i_store_fwd_buffer (.*);

  typedef struct { logic [15:0] a; logic [31:0] d; bit sent; } ent_t;
  ent_t        q[$];
  logic [15:0] pend[$];
  logic [31:0] cmem [logic [15:0]];
  bit          m_mode = 0, m_err = 0, rsp_from_pend = 0;
  int          n_chk = 0, n_bad = 0;

  function automatic logic [31:0] crd(input logic [15:0] a);
    return cmem.exists(a) ? cmem[a] : 32'h0;
  endfunction

  function automatic logic [15:0] pick_addr();
    // R10: 0x0010 and 0x1010 differ only in high bits
    case ($urandom % 5)
      0: return 16'h0010;
      1: return 16'h1010;
      2: return 16'h0011;
      3: return 16'h0200;
      default: return 16'h0013;
    endcase
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic compare_cycle();
    bit hit = 0, rq = 0, ok, lowmatch = 0;
    logic [31:0] fd = '0;
    logic [15:0] ra = '0;
    foreach (q[i]) begin
      if (q[i].a == ld_addr) begin hit = 1; fd = q[i].d; end
      else if (q[i].a[7:0] == ld_addr[7:0]) lowmatch = 1;
      if (!rq && !q[i].sent) begin rq = 1; ra = q[i].a; end
    end
    ok = rsp_valid && q.size() > 0 && q[0].sent && q[0].a == rsp_addr;
    chk("R2 st_ready", st_ready, q.size() < 4);
    chk("R3 req_valid", req_valid, rq);
    if (rq) chk("R3 req_addr", req_addr, ra);
    chk(rsp_valid && !ok ? "R5 cw_valid" : "R4 cw_valid", cw_valid, ok);
    if (ok) begin
      chk("R4 cw_addr", cw_addr, q[0].a);
      chk("R4 cw_data", cw_data, q[0].d);
    end
    chk("R5 sb_err", sb_err, m_err);
    chk("R8 cache_rd_addr", cache_rd_addr, ld_addr);
    if (ld_valid) begin
      string r;
      r = hit ? (m_mode ? "R7" : "R6") : (lowmatch ? "R10" : "R8");
      if (m_mode != strict_mode && hit) r = "R9";
      chk({r, " ld_ready"}, ld_ready, !(m_mode && hit));
      if (!(m_mode && hit))
        chk({r, " ld_data"}, ld_data, hit ? fd : crd(ld_addr));
    end
  endtask

  task automatic update_model();
    bit ok, rq_done = 0;
    ok = rsp_valid && q.size() > 0 && q[0].sent && q[0].a == rsp_addr;
    if (q.size() == 0) m_mode = strict_mode;
    if (rsp_valid && !ok) m_err = 1;
    if (req_ready) foreach (q[i]) if (!rq_done && !q[i].sent) begin
      q[i].sent = 1; rq_done = 1; pend.push_back(q[i].a);
    end
    if (rsp_from_pend) void'(pend.pop_front());
    if (ok) begin cmem[q[0].a] = q[0].d; void'(q.pop_front()); end
    if (st_valid && q.size() < (ok ? 5 : 4) && !(ok && q.size() == 3 && 0))
      ;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 st_ready", st_ready, 1);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 cw_valid", cw_valid, 0);
    chk("R1 sb_err", sb_err, 0);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit full_before;
      @(negedge clk);
      full_before = q.size() >= 4;
      strict_mode = ((cyc / 600) % 2) == 1;
      st_valid  = ($urandom % 2) == 0 && cyc < 3800;
      st_addr   = pick_addr();
      st_data   = $urandom;
      ld_valid  = ($urandom % 2) == 0;
      ld_addr   = pick_addr();
      req_ready = (cyc < 40 || (cyc >= 1200 && cyc < 1230)) ? 1'b0 : ($urandom % 4) != 0;
      rsp_from_pend = 0;
      rsp_valid = 1'b0;
      if (cyc == 2900) begin
        rsp_valid = 1'b1; rsp_addr = 16'hBEEF;
      end else if (pend.size() > 0 && ($urandom % 3) == 0) begin
        rsp_valid = 1'b1; rsp_addr = pend[0]; rsp_from_pend = 1;
      end
      #1 cache_rd_data = crd(cache_rd_addr);
      #1 compare_cycle();
      @(posedge clk);
      begin
        bit push;
        push = st_valid && !full_before;
        update_model();
        if (push) q.push_back('{a: st_addr, d: st_data, sent: 0});
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule